// File: doc/BRIEF.md
# Peripheral Clock Gate and Reset Controller

This block sits beside a group of peripherals and controls their clock gates and reset lines. There are twenty consumers, split into three bridge groups: the main interconnect group (0), the fast peripheral group (1) and the slow peripheral group (2). Software turns a gate on or off by writing a 16-bit consumer code to one of two command addresses. One address sets the gate and the other clears it, so the gate itself never needs a read-modify-write. Each group has a status register that reports gate state one bit per consumer. Each group also has a reset register, in which a set bit holds that consumer in reset.

Some consumers are not steered by software. Bridge and bus-master consumers follow a hardware request line. The interrupt controller and the real-time clock have no code, and their gates stay on permanently. The console UART cannot be switched off by a clear command. Each consumer k drives `gate_o[k]` and `rst_o[k]`.

Consumer table (index: name, group, status bit, reset bit, flags), where hw means hardware-controlled and fixed means it has no code:
0 cpu g0 s3 r3 hw; 1 dma g0 s4 r4 hw; 2 nand g0 s6 r6; 3 gfx g0 s8 r8 hw; 4 shmem g0 s9 r9; 5 ahb bridge g0 s10 r10 hw; 6 irq ctrl g0 s12 r12 fixed; 7 extmem g0 s5 r5; 8 fast bridge g1 s0 r0 hw; 9 i2c0 g1 s1 r1; 10 i2c1 g1 s2 r2; 11 sdio g1 s5 r5; 12 spi g1 s6 r6; 13 slow bridge g2 s0 r0 hw; 14 uart g2 s1 r1 (protected); 15 gpio g2 s4 r4; 16 keypad g2 s6 r5; 17 rtc g2 (no status) r6 fixed; 18 app timer g2 s7 r7; 19 acc timer g2 s8 r8.

Top module: `pcg_ctrl`

## Requirements
- R1: A write of a code to address 0 turns on, at the next clock edge, the gate of the software-controlled consumer whose code matches. Code = (group << 8) | status bit, for example nand = 0x0006 and keypad = 0x0206.
- R2: A write of a matching code to address 1 turns that consumer's gate off at the next clock edge, and no other gate changes.
- R3: Hardware-controlled consumers (indices 0, 1, 3, 5, 8, 13) ignore both command addresses. Their gate equals `hw_req_i[k]` as it was sampled at the previous clock edge.
- R4: The code 0xFFFF, and any code that matches no software-controlled consumer (for example 0x0000, 0x0103 and 0x0205), has no effect on any gate when written to address 0 or address 1.
- R5: The console UART (index 14) stays on when its code 0x0201 is written to address 1.
- R6: The consumers without a code (irq ctrl, index 6, and rtc, index 17) drive their gate at 1 from reset onward.
- R7: Addresses 2, 3 and 4 read the status of groups 0, 1 and 2. Each consumer that has a status bit shows its gate at the status-bit position given in the consumer table, and every other bit reads 0. Reads are combinational and reflect a command written at the previous edge. Addresses 0 and 1 read as 0.
- R8: Addresses 5, 6 and 7 are the reset registers of groups 0, 1 and 2. `rst_o[k]` equals bit (reset bit of k) of its group's register, and 1 means held in reset. Writes store only the bits used by consumers (masks 0x1778, 0x0067 and 0x01F3), unused bits read 0, and a write takes effect at the next edge.
- R9: After reset, every reset register equals its mask, so all `rst_o` bits are 1. Every software-controlled gate and every hardware-controlled gate is off.
- R10: The keypad resets through bit 5 of the group 2 reset register but reports through bit 6 of the group 2 status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address (0 set cmd, 1 clear cmd, 5..7 reset regs) |
| wr_data_i | input | 16 | Write data or consumer code |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 16 | Read data, combinational from rd_addr_i |
| hw_req_i | input | 20 | Gate requests for hardware-controlled consumers |
| gate_o | output | 20 | Clock gate enable per consumer |
| rst_o | output | 20 | Reset per consumer, 1 = held |

## Verification
Every write and every hardware request is captured at one clock edge, and its effect shows on `gate_o`, `rst_o` and the status read exactly one edge later. The read data itself has no register in its path. The bench applies each stimulus just after a falling edge and queues the gate, reset and read-back values it expects after the following rising edge. A monitor compares them a short time after that rising edge, so each result is checked in the first cycle in which it is due. Commands that must have no effect are followed by a read of the affected status register in that same cycle.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

    localparam int unsigned NUM_CONS     = 20;
    localparam int unsigned NUM_GRP      = 3;
    localparam int unsigned REG_W        = 16;
    localparam int unsigned ADDR_W       = 3;
    localparam int unsigned GRP_W        = 2;
    localparam int unsigned BIT_W        = $clog2(REG_W);
    localparam int unsigned CODE_GRP_LSB = 8;
    localparam logic [REG_W-1:0] CODE_VOID = '1;

    // Register map: command ports first, then status, then reset registers
    typedef enum logic [ADDR_W-1:0] {
        A_SET, A_CLR, A_ST0, A_ST1, A_ST2, A_RS0, A_RS1, A_RS2
    } addr_e;

    typedef struct packed {
        logic [GRP_W-1:0] grp;
        logic [BIT_W-1:0] sbit;
        logic [BIT_W-1:0] rbit;
        logic             coded;  // reachable by a command code
        logic             hw;     // follows a hardware request
        logic             stat;   // has a status bit
        logic             keep;   // clear command is refused
    } cons_t;

    // flags = {coded, hw, stat, keep}
    function automatic cons_t mk(input int unsigned g, input int unsigned s,
                                 input int unsigned r, input logic [3:0] flags);
        cons_t x;
        x.grp   = GRP_W'(g);
        x.sbit  = BIT_W'(s);
        x.rbit  = BIT_W'(r);
        x.coded = flags[3];
        x.hw    = flags[2];
        x.stat  = flags[1];
        x.keep  = flags[0];
        return x;
    endfunction

    function automatic cons_t cons_info(input int unsigned k);
        case (k)
            0:  return mk(0, 3, 3, 4'b1110);
            1:  return mk(0, 4, 4, 4'b1110);
            2:  return mk(0, 6, 6, 4'b1010);
            3:  return mk(0, 8, 8, 4'b1110);
            4:  return mk(0, 9, 9, 4'b1010);
            5:  return mk(0, 10, 10, 4'b1110);
            6:  return mk(0, 12, 12, 4'b0010);
            7:  return mk(0, 5, 5, 4'b1010);
            8:  return mk(1, 0, 0, 4'b1110);
            9:  return mk(1, 1, 1, 4'b1010);
            10: return mk(1, 2, 2, 4'b1010);
            11: return mk(1, 5, 5, 4'b1010);
            12: return mk(1, 6, 6, 4'b1010);
            13: return mk(2, 0, 0, 4'b1110);
            14: return mk(2, 1, 1, 4'b1011);
            15: return mk(2, 4, 4, 4'b1010);
            16: return mk(2, 6, 5, 4'b1010);
            17: return mk(2, 0, 6, 4'b0000);
            18: return mk(2, 7, 7, 4'b1010);
            19: return mk(2, 8, 8, 4'b1010);
            default: return mk(0, 0, 0, 4'b0000);
        endcase
    endfunction

    function automatic logic [REG_W-1:0] cons_code(input int unsigned k);
        cons_t i;
        logic [REG_W-1:0] c;
        i = cons_info(k);
        c = '0;
        if (!i.coded) return CODE_VOID;
        c[BIT_W-1:0] = i.sbit;
        c[CODE_GRP_LSB +: GRP_W] = i.grp;
        return c;
    endfunction

    function automatic logic [NUM_CONS-1:0] hw_mask();
        logic [NUM_CONS-1:0] m;
        m = '0;
        for (int unsigned k = 0; k < NUM_CONS; k++) m[k] = cons_info(k).hw;
        return m;
    endfunction

    function automatic logic [NUM_CONS-1:0] sw_mask();
        logic [NUM_CONS-1:0] m;
        m = '0;
        for (int unsigned k = 0; k < NUM_CONS; k++)
            m[k] = cons_info(k).coded && !cons_info(k).hw;
        return m;
    endfunction

    function automatic logic [NUM_CONS-1:0] fixed_mask();
        logic [NUM_CONS-1:0] m;
        m = '0;
        for (int unsigned k = 0; k < NUM_CONS; k++)
            m[k] = !cons_info(k).coded && !cons_info(k).hw;
        return m;
    endfunction

    function automatic logic [NUM_CONS-1:0] keep_mask();
        logic [NUM_CONS-1:0] m;
        m = '0;
        for (int unsigned k = 0; k < NUM_CONS; k++) m[k] = cons_info(k).keep;
        return m;
    endfunction

    function automatic logic [NUM_GRP-1:0][REG_W-1:0] rst_masks();
        logic [NUM_GRP-1:0][REG_W-1:0] m;
        cons_t i;
        m = '0;
        for (int unsigned k = 0; k < NUM_CONS; k++) begin
            i = cons_info(k);
            m[i.grp][i.rbit] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/pcg_code_match.sv
module pcg_code_match
    import pcg_pkg::*;
(
    input  logic [REG_W-1:0]    code_i,
    output logic [NUM_CONS-1:0] match_o
);
    localparam logic [NUM_CONS-1:0] SW_M = sw_mask();

    always_comb begin
        match_o = '0;
        for (int unsigned k = 0; k < NUM_CONS; k++) begin
            match_o[k] = SW_M[k] && (code_i != CODE_VOID) && (code_i == cons_code(k));
        end
    end
endmodule

// File: rtl/pcg_gate_bank.sv
module pcg_gate_bank
    import pcg_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_CONS-1:0] set_i,
    input  logic [NUM_CONS-1:0] clr_i,
    input  logic [NUM_CONS-1:0] hw_req_i,
    output logic [NUM_CONS-1:0] gate_o
);
    localparam logic [NUM_CONS-1:0] HW_M    = hw_mask();
    localparam logic [NUM_CONS-1:0] SW_M    = sw_mask();
    localparam logic [NUM_CONS-1:0] FIXED_M = fixed_mask();
    localparam logic [NUM_CONS-1:0] KEEP_M  = keep_mask();

    typedef struct packed {
        logic [NUM_CONS-1:0] gate;
    } gate_st_t;

    gate_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int unsigned k = 0; k < NUM_CONS; k++) begin
            if (HW_M[k]) begin
                s_d.gate[k] = hw_req_i[k];
            end else if (FIXED_M[k]) begin
                s_d.gate[k] = 1'b1;
            end else if (set_i[k]) begin
                s_d.gate[k] = 1'b1;
            end else if (clr_i[k] && !KEEP_M[k]) begin
                s_d.gate[k] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q.gate <= FIXED_M;
        else         s_q <= s_d;
    end

    assign gate_o = s_q.gate;

    // R3: hardware-steered gates track the request one edge later
    p_hw_follow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_ni |=> (s_q.gate & HW_M) == ($past(hw_req_i) & HW_M));

    // R5: a protected gate never drops once on
    p_keep_on_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_ni |=> ($past(s_q.gate) & KEEP_M & ~s_q.gate) == '0);

    // R4: without a command hit, software gates hold
    p_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_i == '0 && clr_i == '0) |=> $stable(s_q.gate & SW_M));

    // R6: code-less consumers are always gated on
    p_fixed_on_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.gate & FIXED_M) == FIXED_M);
endmodule

// File: rtl/pcg_reset_bank.sv
module pcg_reset_bank
    import pcg_pkg::*;
(
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic                            wr_i,
    input  logic [GRP_W-1:0]                sel_i,
    input  logic [REG_W-1:0]                data_i,
    output logic [NUM_GRP-1:0][REG_W-1:0]   regs_o,
    output logic [NUM_CONS-1:0]             rst_o
);
    localparam logic [NUM_GRP-1:0][REG_W-1:0] MASKS = rst_masks();

    typedef struct packed {
        logic [NUM_GRP-1:0][REG_W-1:0] regs;
    } rst_st_t;

    rst_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_i && (32'(sel_i) < NUM_GRP)) begin
            s_d.regs[sel_i] = data_i & MASKS[sel_i];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q.regs <= MASKS;
        else         s_q <= s_d;
    end

    assign regs_o = s_q.regs;

    always_comb begin
        rst_o = '0;
        for (int unsigned k = 0; k < NUM_CONS; k++) begin
            rst_o[k] = s_q.regs[cons_info(k).grp][cons_info(k).rbit];
        end
    end

    // R8: a write lands masked at the next edge
    p_rst_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> regs_o[$past(sel_i)] == ($past(data_i) & MASKS[$past(sel_i)]));

    // R8: registers hold without a write
    p_rst_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_i |=> $stable(regs_o));
endmodule

// File: rtl/pcg_read_mux.sv
module pcg_read_mux
    import pcg_pkg::*;
(
    input  logic [ADDR_W-1:0]              rd_addr_i,
    input  logic [NUM_CONS-1:0]            gate_i,
    input  logic [NUM_GRP-1:0][REG_W-1:0]  regs_i,
    output logic [REG_W-1:0]               rd_data_o
);
    logic [ADDR_W-1:0] st_off;
    logic [ADDR_W-1:0] rs_off;

    always_comb begin
        st_off    = rd_addr_i - ADDR_W'(A_ST0);
        rs_off    = rd_addr_i - ADDR_W'(A_RS0);
        rd_data_o = '0;
        if (rd_addr_i >= A_ST0 && rd_addr_i <= A_ST2) begin
            for (int unsigned k = 0; k < NUM_CONS; k++) begin
                if (cons_info(k).stat && cons_info(k).grp == st_off[GRP_W-1:0]) begin
                    rd_data_o[cons_info(k).sbit] = gate_i[k];
                end
            end
        end else if (rd_addr_i >= A_RS0) begin
            rd_data_o = regs_i[rs_off[GRP_W-1:0]];
        end
    end
endmodule

// File: rtl/pcg_ctrl.sv
module pcg_ctrl
    import pcg_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   wr_addr_i,
    input  logic [REG_W-1:0]    wr_data_i,
    input  logic [ADDR_W-1:0]   rd_addr_i,
    output logic [REG_W-1:0]    rd_data_o,
    input  logic [NUM_CONS-1:0] hw_req_i,
    output logic [NUM_CONS-1:0] gate_o,
    output logic [NUM_CONS-1:0] rst_o
);
    localparam logic [NUM_CONS-1:0] SW_M = sw_mask();

    logic [NUM_CONS-1:0]            hit;
    logic [NUM_CONS-1:0]            set_vec;
    logic [NUM_CONS-1:0]            clr_vec;
    logic                           rst_wr;
    logic [ADDR_W-1:0]              rst_off;
    logic [NUM_GRP-1:0][REG_W-1:0]  rst_regs;

    pcg_code_match i_match (
        .code_i  (wr_data_i),
        .match_o (hit)
    );

    always_comb begin
        set_vec = (wr_en_i && wr_addr_i == A_SET) ? hit : '0;
        clr_vec = (wr_en_i && wr_addr_i == A_CLR) ? hit : '0;
        rst_wr  = wr_en_i && (wr_addr_i >= A_RS0);
        rst_off = wr_addr_i - ADDR_W'(A_RS0);
    end

    pcg_gate_bank i_gates (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .set_i    (set_vec),
        .clr_i    (clr_vec),
        .hw_req_i (hw_req_i),
        .gate_o   (gate_o)
    );

    pcg_reset_bank i_resets (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wr_i   (rst_wr),
        .sel_i  (rst_off[GRP_W-1:0]),
        .data_i (wr_data_i),
        .regs_o (rst_regs),
        .rst_o  (rst_o)
    );

    pcg_read_mux i_rdmux (
        .rd_addr_i (rd_addr_i),
        .gate_i    (gate_o),
        .regs_i    (rst_regs),
        .rd_data_o (rd_data_o)
    );

    // R1: a code selects at most one consumer
    p_single_hit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(set_vec | clr_vec));

    // R4: the void code leaves every software gate untouched
    p_void_code_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_data_i == CODE_VOID) |=> $stable(gate_o & SW_M));
endmodule

// File: tb/test_pcg_ctrl.sv
`timescale 1ns/1ps
module test_pcg_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [2:0]  wa = '0;
    logic [15:0] wd = '0;
    logic [2:0]  ra = '0;
    logic [19:0] hw = '0;
    logic [15:0] rd_data;
    logic [19:0] gate;
    logic [19:0] rst;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pcg_ctrl i_pcg_ctrl (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (we),
        .wr_addr_i (wa),
        .wr_data_i (wd),
        .rd_addr_i (ra),
        .rd_data_o (rd_data),
        .hw_req_i  (hw),
        .gate_o    (gate),
        .rst_o     (rst)
    );

    // Consumer table from the requirements
    int unsigned t_grp[20];
    int unsigned t_sb[20];
    int unsigned t_rb[20];
    bit t_cod[20], t_hw[20], t_st[20], t_kp[20];

    task automatic put(input int k, input int unsigned g, input int unsigned s,
                       input int unsigned r, input bit c, input bit h,
                       input bit st, input bit kp);
        t_grp[k] = g; t_sb[k] = s; t_rb[k] = r;
        t_cod[k] = c; t_hw[k] = h; t_st[k] = st; t_kp[k] = kp;
    endtask

    function automatic logic [15:0] tcode(input int k);
        return 16'((t_grp[k] << 8) | t_sb[k]);
    endfunction

    function automatic logic [15:0] tmask(input int unsigned g);
        logic [15:0] m = '0;
        for (int k = 0; k < 20; k++) if (t_grp[k] == g) m[t_rb[k]] = 1'b1;
        return m;
    endfunction

    logic [19:0] gm;
    logic [15:0] rm[3];

    typedef struct {
        logic [19:0] g;
        logic [19:0] r;
        logic [15:0] d;
        string       tag;
    } item_t;
    item_t sbq[$];

    function automatic logic [15:0] exp_rd(input logic [2:0] a);
        logic [15:0] v = '0;
        if (a >= 3'd2 && a <= 3'd4) begin
            for (int k = 0; k < 20; k++)
                if (t_st[k] && t_grp[k] == 32'(a - 3'd2)) v[t_sb[k]] = gm[k];
        end else if (a >= 3'd5) begin
            v = rm[a - 3'd5];
        end
        return v;
    endfunction

    function automatic logic [19:0] exp_rst();
        logic [19:0] v = '0;
        for (int k = 0; k < 20; k++) v[k] = rm[t_grp[k]][t_rb[k]];
        return v;
    endfunction

    // Driver: apply one cycle of stimulus and queue the state expected after the edge
    task automatic step(input bit w, input logic [2:0] a, input logic [15:0] d,
                        input logic [2:0] r, input logic [19:0] h, input string tag);
        item_t it;
        @(negedge clk);
        we = w; wa = a; wd = d; ra = r; hw = h;
        for (int k = 0; k < 20; k++) begin
            if (t_hw[k]) gm[k] = h[k];
            else if (!t_cod[k]) gm[k] = 1'b1;
            else if (w && a == 3'd0 && d == tcode(k)) gm[k] = 1'b1;
            else if (w && a == 3'd1 && d == tcode(k) && !t_kp[k]) gm[k] = 1'b0;
        end
        if (w && a >= 3'd5) rm[a - 3'd5] = d & tmask(32'(a - 3'd5));
        it.g = gm; it.r = exp_rst(); it.d = exp_rd(r); it.tag = tag;
        sbq.push_back(it);
    endtask

    // Monitor: compare after the edge that registers each queued stimulus
    always @(posedge clk) begin
        item_t it;
        #2;
        if (sbq.size() != 0) begin
            it = sbq.pop_front();
            checks += 3;
            if (gate !== it.g) begin
                errors++;
                $display("FAIL %s gate_o actual=%h expected=%h", it.tag, gate, it.g);
            end
            if (rst !== it.r) begin
                errors++;
                $display("FAIL %s rst_o actual=%h expected=%h", it.tag, rst, it.r);
            end
            if (rd_data !== it.d) begin
                errors++;
                $display("FAIL %s rd_data_o (addr %0d) actual=%h expected=%h",
                         it.tag, ra, rd_data, it.d);
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL all requirements: watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        put(0, 0, 3, 3, 1, 1, 1, 0);   put(1, 0, 4, 4, 1, 1, 1, 0);
        put(2, 0, 6, 6, 1, 0, 1, 0);   put(3, 0, 8, 8, 1, 1, 1, 0);
        put(4, 0, 9, 9, 1, 0, 1, 0);   put(5, 0, 10, 10, 1, 1, 1, 0);
        put(6, 0, 12, 12, 0, 0, 1, 0); put(7, 0, 5, 5, 1, 0, 1, 0);
        put(8, 1, 0, 0, 1, 1, 1, 0);   put(9, 1, 1, 1, 1, 0, 1, 0);
        put(10, 1, 2, 2, 1, 0, 1, 0);  put(11, 1, 5, 5, 1, 0, 1, 0);
        put(12, 1, 6, 6, 1, 0, 1, 0);  put(13, 2, 0, 0, 1, 1, 1, 0);
        put(14, 2, 1, 1, 1, 0, 1, 1);  put(15, 2, 4, 4, 1, 0, 1, 0);
        put(16, 2, 6, 5, 1, 0, 1, 0);  put(17, 2, 0, 6, 0, 0, 0, 0);
        put(18, 2, 7, 7, 1, 0, 1, 0);  put(19, 2, 8, 8, 1, 0, 1, 0);

        gm = '0; gm[6] = 1'b1; gm[17] = 1'b1;
        for (int g = 0; g < 3; g++) rm[g] = tmask(g);

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R9 and R6: state after reset
        step(0, 3'd0, 16'h0000, 3'd2, '0, "R9");
        step(0, 3'd0, 16'h0000, 3'd5, '0, "R9");
        step(0, 3'd0, 16'h0000, 3'd7, '0, "R6");
        // R1: enable by code, then every software consumer
        step(1, 3'd0, 16'h0006, 3'd2, '0, "R1");
        for (int k = 0; k < 20; k++)
            if (t_cod[k] && !t_hw[k]) step(1, 3'd0, tcode(k), 3'(2 + t_grp[k]), '0, "R1");
        // R2: disable by code
        step(1, 3'd1, 16'h0101, 3'd3, '0, "R2");
        step(1, 3'd1, 16'h0009, 3'd2, '0, "R2");
        // R4: void and unmatched codes
        step(1, 3'd0, 16'hFFFF, 3'd2, '0, "R4");
        step(1, 3'd1, 16'hFFFF, 3'd4, '0, "R4");
        step(1, 3'd1, 16'h0103, 3'd3, '0, "R4");
        step(1, 3'd0, 16'h0205, 3'd4, '0, "R4");
        step(1, 3'd1, 16'h0000, 3'd2, '0, "R4");
        // R3: hardware-controlled consumers
        step(1, 3'd0, 16'h0003, 3'd2, '0, "R3");
        step(0, 3'd0, 16'h0000, 3'd2, 20'hFFFFF, "R3");
        step(1, 3'd1, 16'h0100, 3'd3, 20'hFFFFF, "R3");
        step(0, 3'd0, 16'h0000, 3'd4, 20'h0A5A5, "R3");
        step(0, 3'd0, 16'h0000, 3'd2, 20'h05A5A, "R3");
        step(0, 3'd0, 16'h0000, 3'd3, '0, "R3");
        // R5: console stays on
        step(1, 3'd1, 16'h0201, 3'd4, '0, "R5");
        step(0, 3'd0, 16'h0000, 3'd4, '0, "R5");
        // R7: command addresses read as zero
        step(0, 3'd0, 16'h0000, 3'd0, '0, "R7");
        step(0, 3'd0, 16'h0000, 3'd1, '0, "R7");
        // R8: reset registers
        step(1, 3'd7, 16'h0000, 3'd7, '0, "R8");
        step(1, 3'd5, 16'hFFFF, 3'd5, '0, "R8");
        step(1, 3'd6, 16'h0000, 3'd6, '0, "R8");
        step(1, 3'd5, 16'h1234, 3'd5, '0, "R8");
        // R10: keypad split bit positions
        step(1, 3'd7, 16'h0020, 3'd7, '0, "R10");
        step(1, 3'd1, 16'h0206, 3'd4, '0, "R10");
        step(1, 3'd0, 16'h0206, 3'd4, '0, "R10");
        step(0, 3'd0, 16'h0000, 3'd4, '0, "R10");

        repeat (2) @(posedge clk);
        #3;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule